// File: doc/BRIEF.md
# Algebraic-Integer Word Transpose Stage

This block sits between a column-pass transform core and four row-pass transform cores in an 8×8 two-dimensional transform. The column core delivers, once per column period, eight coefficients of one column, each coefficient carried as four independent integer channels (an exact algebraic-integer word). The stage keeps every channel of every coefficient in its own shift chain of eight taps. The chains advance only on the column-valid strobe, so a gap in the input stream freezes them.

When the eighth column of a block has been captured, a fixed cross-wiring of the tap outputs presents the transposed block. A holding bank snapshots it, and a playout sequencer walks the eight rows in order, one row every eight master cycles. Thirty-two 8:1 multiplexers, one per (channel, element) lane and all sharing a 3-bit row select, feed the row cores. Row core q receives channel q of every element.

No arithmetic and no decoding take place here. The output is an AI-encoded row plus a one-cycle row-valid strobe at the start of each row slot.

Top module: `aitb_top`

## Requirements
- R1: After a synchronous active-low reset, `row_vld` is 0 and `row_data` is all zeros until the first block completes.
- R2: Input word for coefficient k, channel h of a column lies at `col_data[(k*4+h)*16 +: 16]`. For the j-th row delivered in a block (j = 0..7), output lane `row_data[(q*8+c)*16 +: 16]` equals channel q of coefficient j of the c-th column captured in that block (c = 0 is the first column captured).
- R3: Each block yields exactly eight `row_vld` pulses of one cycle each, in row order 0..7, with consecutive pulses exactly 8 cycles apart.
- R4: The first `row_vld` of a block is high in the second cycle after the clock edge that captures the block's eighth column.
- R5: `row_data` changes only together with a `row_vld` pulse and holds its value for the whole 8-cycle row slot and after playout ends.
- R6: A column is captured only on a clock edge with `col_vld` high. `col_data` is ignored otherwise, and pauses of any length between columns (spacing of at least 8 cycles) do not alter the block contents.
- R7: Outside a block's 64-cycle playout, `row_vld` stays low. A new block may complete no earlier than the last cycle of the previous playout, and it then restarts at row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| col_vld | input | 1 | One-cycle strobe: a column is present on `col_data` |
| col_data | input | 512 | Eight coefficients × four channels × 16 bits, coefficient-major |
| row_vld | output | 1 | One-cycle strobe at the start of each row slot |
| row_data | output | 512 | Four row-core channels × eight elements × 16 bits, channel-major |

## Verification
The bench builds the stage with its default geometry: 8 points, 4 channels and 16-bit words. This is the full 8×8 block with all 32 multiplexer lanes and every row-select code in play. Blocks are sent back to back at the minimum 8-cycle column spacing, which makes each new block complete exactly on the last playout cycle of the previous one. Other blocks use randomly stretched spacing, or a long pause in mid-block while the previous block is still playing out, with garbage on `col_data` in every idle cycle. A block built only from the two sign-limit words exercises every bit of each lane.

// File: rtl/aitb_pkg.sv
// Shared definitions for the AI-word transpose stage.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package aitb_pkg;

    // Playout sequencer state.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_PLAY = 1'b1
    } seq_state_e;

    // Flat slot index of a two-level (major, minor) word arrangement.
    function automatic int unsigned word_slot(input int unsigned major,
                                              input int unsigned minor,
                                              input int unsigned minor_n);
        return major * minor_n + minor;
    endfunction

endpackage

// File: rtl/aitb_tap_chain.sv
// One tap-delay chain for a single integer channel of a single coefficient.
// tap 0 holds the newest column and tap DEPTH-1 the oldest.
// Assumes: shift is a one-cycle column strobe; the chain holds when shift is low.
module aitb_tap_chain #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift,
    input  logic [W-1:0]       din,
    output logic [DEPTH*W-1:0] taps
);

    logic [W-1:0] tap_q [DEPTH];

    // Advance the chain by one column on each accepted column strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tap_q[i] <= '0;
        end else if (shift) begin
            tap_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) tap_q[i] <= tap_q[i-1];
        end
    end

    // Flatten the taps for the fixed cross-wiring above.
    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign taps[g*W +: W] = tap_q[g];
    end

    // R6: without a strobe the chain keeps its contents.
    p_taps_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(taps));

    // R2: an accepted word enters at the newest tap.
    p_newest_enters_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> taps[0 +: W] == $past(din));

endmodule

// File: rtl/aitb_seq.sv
// Column counter and row playout sequencer.
// Counts accepted columns modulo PTS, raises a load pulse one cycle after
// the last column of a block, then runs a PTS*PTS-cycle modular index
// whose upper bits are the row select and whose lower bits time each slot.
// Assumes: PTS is a power of two; columns are at least PTS cycles apart.
module aitb_seq
    import aitb_pkg::*;
#(
    parameter int unsigned PTS = 8,
    localparam int unsigned CW = $clog2(PTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          col_vld,
    output logic          load,
    output logic [CW-1:0] sel,
    output logic          strobe,
    output logic          busy
);

    localparam int unsigned SW = 2 * CW;
    localparam logic [SW-1:0] LAST = SW'(PTS * PTS - 1);
    localparam logic [CW-1:0] LAST_COL = CW'(PTS - 1);

    logic [CW-1:0] col_q;
    logic          load_q;
    logic [SW-1:0] cnt_q;
    seq_state_e    state_q;

    // Count accepted columns within the current block.
    always_ff @(posedge clk) begin
        if (!rst_n) col_q <= '0;
        else if (col_vld) col_q <= col_q + 1'b1;
    end

    // Flag block completion one cycle after its last column is captured.
    always_ff @(posedge clk) begin
        if (!rst_n) load_q <= 1'b0;
        else load_q <= col_vld && (col_q == LAST_COL);
    end

    // Step the modular playout index through one block of row slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else if (load_q) begin
            state_q <= SEQ_PLAY;
            cnt_q   <= '0;
        end else if (state_q == SEQ_PLAY) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) state_q <= SEQ_IDLE;
        end
    end

    assign load   = load_q;
    assign sel    = cnt_q[SW-1:CW];
    assign busy   = (state_q == SEQ_PLAY);
    assign strobe = busy && (cnt_q[CW-1:0] == '0);

    // R6: columns arrive as isolated one-cycle strobes.
    p_col_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        col_vld |=> !col_vld);

    // R7: a new block never cuts into an unfinished playout.
    p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |-> (state_q == SEQ_IDLE || cnt_q == LAST));

endmodule

// File: rtl/aitb_xbar_hold.sv
// Fixed cross-wiring of the tap outputs into transposed order plus a
// holding bank that snapshots the block for playout.
// Output slot ((k*NCH+h)*PTS + c) holds channel h of coefficient k of
// column c, where c = 0 is the oldest column (tap PTS-1).
// Assumes: load pulses once per completed block.
module aitb_xbar_hold
    import aitb_pkg::*;
#(
    parameter int unsigned W   = 16,
    parameter int unsigned PTS = 8,
    parameter int unsigned NCH = 4,
    localparam int unsigned NW = PTS * NCH * PTS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [NW*W-1:0] taps,
    output logic [NW*W-1:0] hold
);

    logic [W-1:0] xw     [NW];
    logic [W-1:0] hold_q [NW];

    // Wiring only: reverse tap age into column order within each chain.
    for (genvar k = 0; k < PTS; k++) begin : g_coef
        for (genvar h = 0; h < NCH; h++) begin : g_chan
            for (genvar c = 0; c < PTS; c++) begin : g_col
                localparam int unsigned CHAIN = word_slot(k, h, NCH);
                localparam int unsigned DST   = word_slot(CHAIN, c, PTS);
                localparam int unsigned SRC   = word_slot(CHAIN, PTS - 1 - c, PTS);
                assign xw[DST] = taps[SRC*W +: W];
            end
        end
    end

    // Capture the transposed block when the column sequencer completes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) hold_q[i] <= '0;
        end else if (load) begin
            for (int i = 0; i < NW; i++) hold_q[i] <= xw[i];
        end
    end

    for (genvar i = 0; i < NW; i++) begin : g_flat
        assign hold[i*W +: W] = hold_q[i];
    end

    // R5: the snapshot only moves on a load.
    p_hold_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(hold));

endmodule

// File: rtl/aitb_row_mux.sv
// NCH*PTS commutating 8:1 row multiplexers sharing one row select.
// Lane (h*PTS + c) carries channel h of element c of the selected row,
// so row core h sees the h-th channel of the whole row.
// Assumes: sel is below PTS (PTS a power of two).
module aitb_row_mux
    import aitb_pkg::*;
#(
    parameter int unsigned W   = 16,
    parameter int unsigned PTS = 8,
    parameter int unsigned NCH = 4,
    localparam int unsigned CW = $clog2(PTS),
    localparam int unsigned NW = PTS * NCH * PTS
) (
    input  logic [CW-1:0]        sel,
    input  logic [NW*W-1:0]      hold,
    output logic [NCH*PTS*W-1:0] lanes
);

    for (genvar h = 0; h < NCH; h++) begin : g_chan
        for (genvar c = 0; c < PTS; c++) begin : g_elem
            logic [W-1:0] cand [PTS];
            // Gather the PTS candidate rows for this lane.
            for (genvar k = 0; k < PTS; k++) begin : g_row
                localparam int unsigned SRC = word_slot(word_slot(k, h, NCH), c, PTS);
                assign cand[k] = hold[SRC*W +: W];
            end
            // Route the selected row to this lane.
            assign lanes[word_slot(h, c, PTS)*W +: W] = cand[sel];
        end
    end

endmodule

// File: rtl/aitb_top.sv
// Real-time transpose stage for four-channel algebraic-integer words.
// Per-channel tap chains capture columns, fixed wiring transposes them,
// a holding bank snapshots each finished block and shared-select
// multiplexers play the rows out, one every PTS cycles, to NCH row cores.
// Assumes: col_vld strobes are at least PTS cycles apart; PTS power of two.
module aitb_top #(
    parameter int unsigned W   = 16,
    parameter int unsigned PTS = 8,
    parameter int unsigned NCH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 col_vld,
    input  logic [PTS*NCH*W-1:0] col_data,
    output logic                 row_vld,
    output logic [NCH*PTS*W-1:0] row_data
);

    localparam int unsigned CW = $clog2(PTS);
    localparam int unsigned NW = PTS * NCH * PTS;

    logic [NW*W-1:0]      taps_all;
    logic [NW*W-1:0]      hold_all;
    logic [NCH*PTS*W-1:0] lanes;
    logic                 load;
    logic [CW-1:0]        sel;
    logic                 strobe;
    logic                 busy;

    // One tap chain per (coefficient, channel).
    for (genvar k = 0; k < PTS; k++) begin : g_coef
        for (genvar h = 0; h < NCH; h++) begin : g_chan
            aitb_tap_chain #(.W(W), .DEPTH(PTS)) u_tap (
                .clk   (clk),
                .rst_n (rst_n),
                .shift (col_vld),
                .din   (col_data[(k*NCH+h)*W +: W]),
                .taps  (taps_all[(k*NCH+h)*PTS*W +: PTS*W])
            );
        end
    end

    aitb_seq #(.PTS(PTS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .col_vld (col_vld),
        .load    (load),
        .sel     (sel),
        .strobe  (strobe),
        .busy    (busy)
    );

    aitb_xbar_hold #(.W(W), .PTS(PTS), .NCH(NCH)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .taps  (taps_all),
        .hold  (hold_all)
    );

    aitb_row_mux #(.W(W), .PTS(PTS), .NCH(NCH)) u_mux (
        .sel   (sel),
        .hold  (hold_all),
        .lanes (lanes)
    );

    // Register the row presented at the start of each slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_vld  <= 1'b0;
            row_data <= '0;
        end else begin
            row_vld <= strobe;
            if (strobe) row_data <= lanes;
        end
    end

    // R4: first row strobe two cycles after the block-complete pulse.
    p_first_row_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ##1 row_vld);

    // R3: each row strobe lasts one cycle.
    p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        row_vld |=> !row_vld);

    // R5: data stays put in the cycle after a strobe.
    p_slot_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        row_vld |=> $stable(row_data));

    // R7: strobes only come out of an active playout.
    p_vld_in_play_r7: assert property (@(posedge clk) disable iff (!rst_n)
        row_vld |-> $past(busy));

endmodule

// File: tb/test_aitb_top.sv
// Scoreboard bench: the driver queues expected rows and first-row times,
// the monitor pops and compares as row strobes appear.
module test_aitb_top;

    localparam int W    = 16;
    localparam int PTS  = 8;
    localparam int NCH  = 4;
    localparam int COLW = PTS * NCH * W;
    localparam int ROWW = NCH * PTS * W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            col_vld = 1'b0;
    logic [COLW-1:0] col_data = '0;
    logic            row_vld;
    logic [ROWW-1:0] row_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int n_blocks = 0;
    int rows_seen = 0;
    int last_strobe = 0;
    int since = 8;
    bit mon_en = 1'b0;
    bit finished = 1'b0;
    logic [ROWW-1:0] exp_q [$];
    int              start_q [$];
    logic [ROWW-1:0] seen_row = '0;

    aitb_top #(.W(W), .PTS(PTS), .NCH(NCH)) i_aitb_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .col_vld  (col_vld),
        .col_data (col_data),
        .row_vld  (row_vld),
        .row_data (row_data)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Send one block of eight columns; mode picks spacing and contents.
    // mode 0: minimum spacing, 1: random spacing, 2: long mid-block pause, 3: sign-limit words
    task automatic send_block(input int mode);
        logic [W-1:0]    m [PTS][PTS][NCH];
        logic [ROWW-1:0] r;
        logic [COLW-1:0] cd;
        int              gap;
        for (int c = 0; c < PTS; c++)
            for (int k = 0; k < PTS; k++)
                for (int h = 0; h < NCH; h++)
                    m[c][k][h] = (mode == 3) ? (((c + k + h) % 2 == 1) ? 16'h8000 : 16'h7fff)
                                             : 16'($urandom);
        // R2: expected row j, lane (q*8+c) = channel q of coefficient j of column c
        for (int k = 0; k < PTS; k++) begin
            r = '0;
            for (int c = 0; c < PTS; c++)
                for (int h = 0; h < NCH; h++)
                    r[(h*PTS+c)*W +: W] = m[c][k][h];
            exp_q.push_back(r);
        end
        for (int c = 0; c < PTS; c++) begin
            cd = '0;
            for (int k = 0; k < PTS; k++)
                for (int h = 0; h < NCH; h++)
                    cd[(k*NCH+h)*W +: W] = m[c][k][h];
            gap = 8;
            if (mode == 1) gap = 8 + int'($urandom % 8);
            if (mode == 2 && c == 3) gap = 40;
            @(negedge clk);
            col_vld  = 1'b1;
            col_data = cd;
            @(negedge clk);
            col_vld = 1'b0;
            // R4: first row expected two edges after the capture edge
            if (c == PTS - 1) start_q.push_back(cyc + 2);
            // R6: garbage on col_data while col_vld is low
            for (int i = 0; i < gap - 1; i++) begin
                for (int b = 0; b < COLW / 32; b++) col_data[b*32 +: 32] = $urandom;
                @(negedge clk);
            end
        end
        n_blocks++;
    endtask

    // Monitor: compare rows, strobe spacing, first-row latency and slot stability.
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            if (row_vld) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R7: unexpected row strobe at cycle %0d, expected none", cyc);
                end else begin
                    logic [ROWW-1:0] e;
                    e = exp_q.pop_front();
                    if (row_data !== e) begin
                        n_bad++;
                        $display("FAIL R2/R6: row %0d actual %h expected %h", rows_seen % PTS, row_data, e);
                    end
                end
                if (rows_seen % PTS == 0) begin
                    n_chk++;
                    if (start_q.size() == 0 || start_q[0] != cyc) begin
                        n_bad++;
                        $display("FAIL R4: first row at cycle %0d expected %0d", cyc,
                                 (start_q.size() == 0) ? -1 : start_q[0]);
                    end
                    if (start_q.size() != 0) void'(start_q.pop_front());
                end else begin
                    n_chk++;
                    if (cyc - last_strobe != PTS) begin
                        n_bad++;
                        $display("FAIL R3: strobe spacing actual %0d expected %0d", cyc - last_strobe, PTS);
                    end
                end
                rows_seen++;
                last_strobe = cyc;
                seen_row = row_data;
                since = 0;
            end else if (since < PTS - 1) begin
                since++;
                n_chk++;
                if (row_data !== seen_row) begin
                    n_bad++;
                    $display("FAIL R5: data moved in slot actual %h expected %h", row_data, seen_row);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        n_chk++;
        if (row_vld !== 1'b0 || row_data !== '0) begin
            n_bad++;
            $display("FAIL R1: reset vld=%b data=%h expected vld=0 data=0", row_vld, row_data);
        end
        mon_en = 1'b1;
        repeat (5) @(negedge clk);
        // Back-to-back blocks at minimum spacing (R3, R7 restart on last playout cycle)
        for (int b = 0; b < 3; b++) send_block(0);
        // Stretched spacing (R6)
        for (int b = 0; b < 3; b++) send_block(1);
        // Long pause in mid-block while the previous block plays out (R6)
        send_block(2);
        send_block(0);
        // Sign-limit words in every lane (R2)
        send_block(3);
        repeat (30) @(negedge clk);
        send_block(2);
        send_block(1);
        repeat (120) @(negedge clk);
        // R7: exactly eight strobes per block and nothing left pending
        n_chk++;
        if (rows_seen != PTS * n_blocks || exp_q.size() != 0 || start_q.size() != 0) begin
            n_bad++;
            $display("FAIL R7: rows actual %0d expected %0d", rows_seen, PTS * n_blocks);
        end
        // R5/R7: outputs idle and held after the final playout
        n_chk++;
        if (row_vld !== 1'b0 || row_data !== seen_row) begin
            n_bad++;
            $display("FAIL R5: idle vld=%b data=%h expected vld=0 data=%h", row_vld, row_data, seen_row);
        end
        finish_run();
    end

endmodule